// File: doc/BRIEF.md
# Timer and External Interrupt Control Register

This block is the byte-wide control and status register that sits beside two timer/counters and two external interrupt pins of an 8051-style core. Firmware sets the run enables of both timers and the trigger style of both pins through a single special-function register port. Hardware raises four request flags: one for each timer overflow and one for each pin event. The interrupt controller clears each flag with a per-source acknowledge pulse.

The external pins are active low. Each pin passes through a two-flop synchroniser. The block then samples it once per machine cycle, which is marked by a strobe input that pulses every 12 oscillator clocks. In edge mode, a pin that is sampled high and then low on the next strobe sets its flag. In level mode, the flag tracks the sampled pin at every strobe. Firmware can read the flags but cannot write them.

Top module: `tmr_xint_ctrl`

## Requirements
- R1: After reset, every bit of the register reads 0, tmr_run_o is 0, and all request outputs are 0.
- R2: A write with sfr_wr_i high and sfr_addr_i equal to 0x88 loads wdata bit 6 into timer-1 run, bit 4 into timer-0 run, bit 2 into pin-1 mode and bit 0 into pin-0 mode, one clock later. A write to any other address changes nothing. Timer run bit i drives tmr_run_o[i].
- R3: A pulse on tmr_ovf_i[i] sets timer flag i in the next clock. Timer 1 reads at bit 7 and timer 0 at bit 5. A write has no effect on these bits.
- R4: ack_tmr_i[i] clears timer flag i in the next clock. If an overflow arrives in the same clock as the acknowledge, the flag stays set.
- R5: Each pin is seen through two synchronising flops. A pin flag changes only on a clock with mc_stb_i high, or on an acknowledge for that pin.
- R6: With the mode bit at 1 (edge), pin flag i is set on a strobe where the synchronised pin is low and the previous strobe's sample was high.
- R7: With the mode bit at 0 (level), every strobe loads pin flag i with the inverse of the synchronised pin. An acknowledge clears the flag until the next strobe.
- R8: Pin 1's flag reads at bit 3 and pin 0's at bit 1. A write cannot change them. ack_xint_i[i] clears flag i, but an edge or level set in the same clock takes priority.
- R9: sfr_rdata_o shows the current register in the same cycle when sfr_addr_i is 0x88, and 0x00 for any other address. irq_tmr_o and irq_xint_o show the flags directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mc_stb_i | input | 1 | One-clock pulse per machine cycle |
| sfr_addr_i | input | 8 | SFR address |
| sfr_wr_i | input | 1 | SFR write enable |
| sfr_wdata_i | input | 8 | SFR write data |
| sfr_rdata_o | output | 8 | SFR read data |
| tmr_ovf_i | input | 2 | Timer overflow pulses |
| ack_tmr_i | input | 2 | Timer interrupt serviced |
| xint_ni | input | 2 | External interrupt pins, active low |
| ack_xint_i | input | 2 | External interrupt serviced |
| tmr_run_o | output | 2 | Timer run enables |
| irq_tmr_o | output | 2 | Timer request flags |
| irq_xint_o | output | 2 | Pin request flags |

## Verification
The pins are driven with slowly changing random levels, both in edge mode and in level mode, while the mode bits are also rewritten at random times. This separates a flag that follows a sample taken at the strobe from one that follows every clock. It also separates a flag set by a falling edge from one set by a low level. Overflows and acknowledges are issued at random, sometimes in the same clock, which tests the rule that a set wins over a clear. Random writes go to both the matching address and other addresses, with all bits set, to show that only the four control bits at 0x88 can be written.

// File: rtl/tmr_xint_pkg.sv
package tmr_xint_pkg;
  localparam int unsigned N_SRC      = 2;
  localparam int unsigned REG_W      = 8;
  localparam int unsigned SYNC_DEPTH = 2;
  localparam logic [7:0]  TCTL_ADDR  = 8'h88;

  function automatic int unsigned tmr_flag_pos(int unsigned i);
    return 5 + 2 * i;
  endfunction

  function automatic int unsigned tmr_run_pos(int unsigned i);
    return 4 + 2 * i;
  endfunction

  function automatic int unsigned xint_flag_pos(int unsigned i);
    return 1 + 2 * i;
  endfunction

  function automatic int unsigned xint_mode_pos(int unsigned i);
    return 2 * i;
  endfunction
endpackage

// File: rtl/tx_sync.sv
module tx_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= {STAGES{RST_VAL}};
    else         chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/tx_tmr_flag.sv
module tx_tmr_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ovf_i,
  input  logic ack_i,
  output logic flag_o
);
  logic flag_q;

  // set beats clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_q <= 1'b0;
    else if (ovf_i) flag_q <= 1'b1;
    else if (ack_i) flag_q <= 1'b0;
  end

  assign flag_o = flag_q;

  AST_TF_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_i |=> flag_o) else $error("tf set");  // R3
  AST_TF_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !ovf_i) |=> !flag_o) else $error("tf clr");  // R4
  AST_TF_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ack_i && !ovf_i) |=> $stable(flag_o)) else $error("tf hold");  // R4
endmodule

// File: rtl/tx_xint_det.sv
module tx_xint_det
  import tmr_xint_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stb_i,
  input  logic pin_ni,
  input  logic edge_mode_i,
  input  logic ack_i,
  output logic flag_o
);
  logic pin_s;
  logic samp_q;
  logic flag_q;
  logic fall;

  tx_sync #(.STAGES(SYNC_DEPTH), .RST_VAL(1'b1)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_ni),
    .q_o   (pin_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    samp_q <= 1'b1;
    else if (stb_i) samp_q <= pin_s;
  end

  assign fall = stb_i && samp_q && !pin_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
    end else if (edge_mode_i) begin
      if (fall)       flag_q <= 1'b1;
      else if (ack_i) flag_q <= 1'b0;
    end else begin
      if (stb_i)      flag_q <= !pin_s;
      else if (ack_i) flag_q <= 1'b0;
    end
  end

  assign flag_o = flag_q;

  AST_EDGE_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_mode_i && stb_i && samp_q && !pin_s) |=> flag_o) else $error("edge");  // R6
  AST_LEVEL_FOLLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!edge_mode_i && stb_i) |=> (flag_o == !$past(pin_s))) else $error("level");  // R7
  AST_XF_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stb_i && !ack_i) |=> $stable(flag_o)) else $error("hold");  // R5
  AST_XF_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !stb_i) |=> !flag_o) else $error("ack");  // R8
endmodule

// File: rtl/tmr_xint_ctrl.sv
module tmr_xint_ctrl
  import tmr_xint_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mc_stb_i,
  input  logic [7:0]       sfr_addr_i,
  input  logic             sfr_wr_i,
  input  logic [REG_W-1:0] sfr_wdata_i,
  output logic [REG_W-1:0] sfr_rdata_o,
  input  logic [N_SRC-1:0] tmr_ovf_i,
  input  logic [N_SRC-1:0] ack_tmr_i,
  input  logic [N_SRC-1:0] xint_ni,
  input  logic [N_SRC-1:0] ack_xint_i,
  output logic [N_SRC-1:0] tmr_run_o,
  output logic [N_SRC-1:0] irq_tmr_o,
  output logic [N_SRC-1:0] irq_xint_o
);
  logic             hit;
  logic             wr_hit;
  logic [N_SRC-1:0] run_q;
  logic [N_SRC-1:0] mode_q;
  logic [N_SRC-1:0] tf;
  logic [N_SRC-1:0] xf;
  logic [REG_W-1:0] reg_w;

  assign hit    = (sfr_addr_i == TCTL_ADDR);
  assign wr_hit = sfr_wr_i && hit;

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        run_q[i]  <= 1'b0;
        mode_q[i] <= 1'b0;
      end else if (wr_hit) begin
        run_q[i]  <= sfr_wdata_i[tmr_run_pos(i)];
        mode_q[i] <= sfr_wdata_i[xint_mode_pos(i)];
      end
    end

    tx_tmr_flag u_tf (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .ovf_i (tmr_ovf_i[i]),
      .ack_i (ack_tmr_i[i]),
      .flag_o(tf[i])
    );

    tx_xint_det u_xd (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .stb_i      (mc_stb_i),
      .pin_ni     (xint_ni[i]),
      .edge_mode_i(mode_q[i]),
      .ack_i      (ack_xint_i[i]),
      .flag_o     (xf[i])
    );
  end

  always_comb begin
    reg_w = '0;
    for (int unsigned i = 0; i < N_SRC; i++) begin
      reg_w[tmr_flag_pos(i)]  = tf[i];
      reg_w[tmr_run_pos(i)]   = run_q[i];
      reg_w[xint_flag_pos(i)] = xf[i];
      reg_w[xint_mode_pos(i)] = mode_q[i];
    end
  end

  assign sfr_rdata_o = hit ? reg_w : '0;
  assign tmr_run_o   = run_q;
  assign irq_tmr_o   = tf;
  assign irq_xint_o  = xf;

  AST_CTRL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_hit |=> ($stable(tmr_run_o) && $stable(mode_q))) else $error("ctrl");  // R2
  AST_CTRL_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_hit |=> (tmr_run_o == {$past(sfr_wdata_i[6]), $past(sfr_wdata_i[4])})) else $error("load");  // R2
  AST_RD_MISS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit |-> (sfr_rdata_o == '0)) else $error("rd");  // R9
endmodule

// File: tb/tmr_xint_ctrl_tb.sv
module tmr_xint_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mc_stb = 1'b0;
  logic [7:0] addr = 8'h88;
  logic       wr = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic [1:0] ovf = '0, ack_t = '0, pin_n = 2'b11, ack_x = '0;
  logic [1:0] run, irq_t, irq_x;

  int checks = 0, errors = 0, stb_cnt = 0;
  bit done = 0;

  // model state
  logic [1:0] m_run = '0, m_mode = '0, m_tf = '0, m_xf = '0;
  logic [1:0] m_s1 = 2'b11, m_s2 = 2'b11, m_samp = 2'b11;

  always #10 clk = ~clk;

  tmr_xint_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .mc_stb_i(mc_stb), .sfr_addr_i(addr),
    .sfr_wr_i(wr), .sfr_wdata_i(wdata), .sfr_rdata_o(rdata),
    .tmr_ovf_i(ovf), .ack_tmr_i(ack_t), .xint_ni(pin_n), .ack_xint_i(ack_x),
    .tmr_run_o(run), .irq_tmr_o(irq_t), .irq_xint_o(irq_x)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_run <= '0; m_mode <= '0; m_tf <= '0; m_xf <= '0;
      m_s1 <= 2'b11; m_s2 <= 2'b11; m_samp <= 2'b11;
    end else begin
      m_s1 <= pin_n;
      m_s2 <= m_s1;
      if (mc_stb) m_samp <= m_s2;
      if (wr && addr == 8'h88) begin
        m_run  <= {wdata[6], wdata[4]};
        m_mode <= {wdata[2], wdata[0]};
      end
      for (int i = 0; i < 2; i++) begin
        if (ovf[i]) m_tf[i] <= 1'b1;           // R3, R4
        else if (ack_t[i]) m_tf[i] <= 1'b0;
        if (m_mode[i]) begin                    // R6
          if (mc_stb && m_samp[i] && !m_s2[i]) m_xf[i] <= 1'b1;
          else if (ack_x[i]) m_xf[i] <= 1'b0;
        end else begin                          // R7
          if (mc_stb) m_xf[i] <= !m_s2[i];
          else if (ack_x[i]) m_xf[i] <= 1'b0;
        end
      end
    end
  end

  function automatic logic [7:0] exp_rd(logic [7:0] a);
    if (a != 8'h88) return 8'h00;
    return {m_tf[1], m_run[1], m_tf[0], m_run[0], m_xf[1], m_mode[1], m_xf[0], m_mode[0]};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    mc_stb = (stb_cnt == 11);
    stb_cnt = (stb_cnt + 1) % 12;
    @(posedge clk);
    @(negedge clk);
    check("R9 rdata", rdata, exp_rd(addr));
    check("R2 run", run, m_run);
    check("R3 R4 irq_tmr", irq_t, m_tf);
    check("R6 R7 R8 irq_xint", irq_x, m_xf);
  endtask

  task automatic idle();
    wr = 0; ovf = '0; ack_t = '0; ack_x = '0;
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R1 reset rdata", rdata, 8'h00);
    check("R1 reset run", run, 2'b00);
    check("R1 reset irq", {irq_t, irq_x}, 4'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 R8: flags not writable
    addr = 8'h88; wr = 1; wdata = 8'hFF; step(); idle();
    check("R3 R8 write ff", rdata, 8'h55);
    // R2: other address ignored
    addr = 8'h89; wr = 1; wdata = 8'h00; step(); idle();
    addr = 8'h88; step();
    check("R2 miss write", rdata, 8'h55);
    check("R2 run out", run, 2'b11);
    // R4: set beats ack
    ovf = 2'b01; step(); idle();
    ovf = 2'b01; ack_t = 2'b01; step(); idle();
    check("R4 set wins", irq_t, 2'b01);
    ack_t = 2'b01; step(); idle();
    check("R4 ack clear", irq_t, 2'b00);
    // R6: edge on pin 0, mode edge
    pin_n = 2'b10; repeat (30) step();
    check("R6 edge flag", irq_x[0], 1'b1);
    ack_x = 2'b01; step(); idle();
    check("R8 ack clears edge", irq_x[0], 1'b0);
    repeat (30) step();
    check("R6 no re-edge while low", irq_x[0], 1'b0);
    // R7: level mode, pin low
    wr = 1; wdata = 8'h00; step(); idle();
    repeat (14) step();
    check("R7 level low", irq_x[0], 1'b1);
    pin_n = 2'b11; repeat (30) step();
    check("R7 level high", irq_x[0], 1'b0);

    for (int n = 0; n < 6000; n++) begin
      idle();
      if ($urandom_range(0, 24) == 0) pin_n[0] = ~pin_n[0];
      if ($urandom_range(0, 24) == 0) pin_n[1] = ~pin_n[1];
      ovf   = ($urandom_range(0, 9) == 0) ? 2'($urandom) : 2'b00;
      ack_t = ($urandom_range(0, 5) == 0) ? 2'($urandom) : 2'b00;
      ack_x = ($urandom_range(0, 5) == 0) ? 2'($urandom) : 2'b00;
      addr  = ($urandom_range(0, 3) == 0) ? 8'($urandom) : 8'h88;
      if ($urandom_range(0, 60) == 0) begin
        wr = 1; wdata = 8'($urandom);
      end
      step();
    end
    idle();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule